// File: doc/BRIEF.md
# Lane Address Coalescer

This unit sits between a group of 32 lanes that issue a memory instruction together and the memory request port behind them. Each lane presents an address and an active flag. The unit finds the distinct aligned 32-byte segments touched by the active lanes. It issues one request per segment, and each request carries a mask of the lanes that segment serves. Neighbouring lanes that read neighbouring words therefore collapse into a handful of transfers. Scattered lanes expand into as many as one transfer per lane.

An instruction is taken on a valid/ready handshake. The unit then holds its input stalled while it issues its requests, one per cycle, each under a valid/ready handshake of its own. When the last request has been accepted, a one-cycle completion strobe reports how many requests the instruction needed. Returning data and reassembling it are handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1 and both `req_valid` and `done_valid` are 0.
- R2: The segment of an address is the address with its low 5 bits forced to zero. `req_addr` always carries such an aligned segment base, including when the lane addresses themselves are unaligned.
- R3: All active lanes whose addresses fall in the same segment are served by exactly one request. That request's `req_mask` has bit i set exactly for those lanes i.
- R4: A lane whose bit in `in_active` is 0 appears in no mask and causes no request, whatever its address.
- R5: Requests leave in ascending order of the lowest-numbered lane among those still unserved. The first request therefore belongs to the segment of the lowest active lane.
- R6: Each distinct segment costs one request, so 32 active lanes that touch 32 different segments produce 32 requests.
- R7: An instruction with no active lanes produces no request and reports a count of 0.
- R8: `in_ready` is 0 from the cycle after an instruction is accepted until the completion strobe has been given. It returns to 1 in the cycle after the strobe.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_mask` hold their values in the next cycle.
- R10: `done_valid` is high for exactly one cycle, one cycle after the last request is accepted. `done_count` then equals the number of requests issued for the instruction.
- R11: With 4-byte elements laid out at a stride of s elements from an aligned base, all 32 lanes active: s=1 needs 4 requests, s=2 needs 8, and s of 8 or more needs 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The unit can take an instruction |
| in_addr | input | 1024 | Lane addresses, lane i at bits [32i+31:32i] |
| in_active | input | 32 | Active flag per lane, bit i for lane i |
| req_valid | output | 1 | A segment request is presented |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 32 | Aligned segment base address |
| req_mask | output | 32 | Lanes served by this request |
| done_valid | output | 1 | One-cycle completion strobe |
| done_count | output | 6 | Requests issued for the finished instruction |

## Verification
`in_ready` falls at the edge that accepts an instruction. The first request is visible in the cycle after that edge. Each later request appears in the cycle after its predecessor is accepted, the completion strobe comes one cycle after the final acceptance, and `in_ready` rises one cycle after that. The bench drives `req_ready` shortly after the rising edge and samples every output on the falling edge, so each handshake is judged on settled values in the cycle where the design produces it. A scoreboard pops expected segment and mask pairs in issue order and expected counts at each strobe, while random back-pressure exercises the hold rule.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*ADDR_W-1:0]  in_addr,
  input  logic [LANES-1:0]         in_active,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [LANES-1:0]         req_mask,
  output logic                     done_valid,
  output logic [$clog2(LANES+1)-1:0] done_count
);
  localparam int OFS_W  = $clog2(SEG_BYTES);
  localparam int SEG_W  = ADDR_W - OFS_W;
  localparam int LIDX_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES+1);

  logic                   busy_q;
  logic [LANES-1:0]       pend_q;
  logic [LANES*SEG_W-1:0] seg_q;
  logic [CNT_W-1:0]       cnt_q;

  logic [LANES*SEG_W-1:0] in_seg;
  logic [LANES-1:0]       unused_lo;
  logic [LIDX_W-1:0]      lead;
  logic [SEG_W-1:0]       lead_seg;
  logic [LANES-1:0]       hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_seg[g*SEG_W +: SEG_W] = in_addr[g*ADDR_W+OFS_W +: SEG_W];
    assign unused_lo[g] = ^in_addr[g*ADDR_W +: OFS_W];
    assign hit[g] = pend_q[g] && (seg_q[g*SEG_W +: SEG_W] == lead_seg);
  end

  always_comb begin
    lead = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (pend_q[i]) lead = LIDX_W'(i);
  end

  assign lead_seg   = seg_q[int'(lead)*SEG_W +: SEG_W];
  assign in_ready   = !busy_q;
  assign req_valid  = busy_q && (pend_q != '0);
  assign req_addr   = {lead_seg, {OFS_W{1'b0}}};
  assign req_mask   = hit;
  assign done_valid = busy_q && (pend_q == '0);
  assign done_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      seg_q  <= '0;
      cnt_q  <= '0;
    end else if (in_valid && in_ready) begin
      busy_q <= 1'b1;
      pend_q <= in_active;
      seg_q  <= in_seg;
      cnt_q  <= '0;
    end else if (req_valid && req_ready) begin
      pend_q <= pend_q & ~hit;
      cnt_q  <= cnt_q + CNT_W'(1);
    end else if (done_valid) begin
      busy_q <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_mask)));

  a_r3_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ((req_mask & $past(req_mask)) == '0));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && in_ready));

  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_count <= CNT_W'(LANES)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && req_valid));
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
  localparam int L = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [L*32-1:0] in_addr = '0;
  logic [L-1:0]  in_active = '0;
  logic          req_valid;
  logic          req_ready = 1;
  logic [31:0]   req_addr;
  logic [L-1:0]  req_mask;
  logic          done_valid;
  logic [5:0]    done_count;

  warp_coalescer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_active(in_active), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_mask(req_mask),
    .done_valid(done_valid), .done_count(done_count));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [31:0] la [L];
  logic [L-1:0] lact;
  logic [31:0] exp_addr_q[$];
  logic [L-1:0] exp_mask_q[$];
  int exp_cnt_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2 req_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  bit hold_prev = 0;
  logic [31:0] hold_addr;
  logic [L-1:0] hold_mask;
  bit want_ready = 0;

  always @(negedge clk) if (rst_n) begin
    if (hold_prev) begin
      check(req_valid && req_addr == hold_addr && req_mask == hold_mask, "R9",
            "request changed under back-pressure", {req_addr, req_mask}, {hold_addr, hold_mask});
    end
    hold_prev = req_valid && !req_ready;
    hold_addr = req_addr;
    hold_mask = req_mask;
    if (want_ready) begin
      check(in_ready, "R8", "in_ready after strobe", 64'(in_ready), 64'd1);
      want_ready = 0;
    end
    if (req_valid && req_ready) begin
      if (exp_addr_q.size() == 0) begin
        check(0, "R4/R6", "unexpected request", {req_addr, req_mask}, 64'd0);
      end else begin
        logic [31:0] ea;
        logic [L-1:0] em;
        ea = exp_addr_q.pop_front();
        em = exp_mask_q.pop_front();
        check(req_addr == ea, "R2/R5", "request segment", 64'(req_addr), 64'(ea));
        check(req_mask == em, "R3/R4", "request mask", 64'(req_mask), 64'(em));
      end
    end
    if (done_valid) begin
      int ec;
      check(exp_addr_q.size() == 0, "R10", "strobe with requests pending",
            64'(exp_addr_q.size()), 64'd0);
      ec = (exp_cnt_q.size() != 0) ? exp_cnt_q.pop_front() : -1;
      check(int'(done_count) == ec, "R10", "done_count", 64'(done_count), 64'(ec));
      want_ready = 1;
    end
  end

  task automatic send();
    logic [L-1:0] pend;
    int n;
    pend = lact;
    n = 0;
    while (pend != '0) begin
      int ld;
      logic [31:0] seg;
      logic [L-1:0] m;
      ld = 0;
      for (int i = L-1; i >= 0; i--) if (pend[i]) ld = i;
      seg = la[ld] & ~32'h1f;
      m = '0;
      for (int j = 0; j < L; j++) if (pend[j] && ((la[j] & ~32'h1f) == seg)) m[j] = 1'b1;
      exp_addr_q.push_back(seg);
      exp_mask_q.push_back(m);
      pend &= ~m;
      n++;
    end
    exp_cnt_q.push_back(n);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = la[i];
    in_active = lact;
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check(!in_ready, "R8", "in_ready after accept", 64'(in_ready), 64'd0);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic stride(input logic [31:0] base, input int step_bytes, input logic [L-1:0] act);
    for (int i = 0; i < L; i++) la[i] = base + 32'(i * step_bytes);
    lact = act;
    send();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !req_valid && !done_valid, "R1", "reset outputs",
          {61'd0, in_ready, req_valid, done_valid}, 64'h4);
    stride(32'h1000, 4, '1);                    // R11 stride 1 -> 4
    stride(32'h2000, 8, '1);                    // R11 stride 2 -> 8
    stride(32'h3000, 32, '1);                   // R6 R11 stride 8 -> 32
    stride(32'h8000, 64, '1);                   // R11 stride 16 -> 32
    stride(32'h4444, 0, '1);                    // R3 all lanes one word
    stride(32'h5000, 4, '0);                    // R7 nothing active
    stride(32'h6000, 4, 32'haaaa_aaaa);         // R4 odd lanes only
    for (int i = 0; i < L; i++) la[i] = 32'h9000 + 32'(i * 4);
    for (int i = 0; i < L; i += 2) la[i] = 32'hdead_0000 + 32'(i * 64);
    lact = 32'haaaa_aaaa;
    send();                                     // R4 inactive lanes scattered
    stride(32'h1010, 4, '1);                    // R2 unaligned base -> 5
    for (int i = 0; i < L; i++) la[i] = 32'h7000 + 32'((L-1-i) * 4);
    lact = '1;
    send();                                     // R5 reversed order
    stall_en = 1;
    stride(32'h1000, 4, '1);                    // R9 under back-pressure
    stride(32'h3000, 32, 32'h0f0f_f0f1);
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < L; i++) la[i] = 32'h2_0000 + $urandom_range(0, 255);
      lact = $urandom;
      send();
    end
    stall_en = 0;
    repeat (4) @(negedge clk);
    check(exp_cnt_q.size() == 0 && exp_addr_q.size() == 0, "R10", "scoreboard drained",
          64'(exp_cnt_q.size() + exp_addr_q.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule